// File: doc/BRIEF.md
# Triangle Downspread Offset Generator

This block produces the digital offset that dithers a frequency synthesizer for spread-spectrum clocking. An internal up/down counter traces a triangle. On each modulation update, the counter value is multiplied by a per-depth step size and negated. The result is a signed word that is zero or negative and can be added straight to the fractional word of a feedback divider. Because the offset is never positive, the synthesized frequency never rises above nominal. The spread only ever pulls it down.

A two-bit select, already decoded from a three-level pin, chooses the depth:
- no spreading;
- a shallow spread of about 1.25 percent;
- a deep spread of exactly twice the shallow peak.

The block samples the select only when the triangle is back at zero offset. A change made in the middle of a sweep therefore never distorts a half-period. Each new offset comes with a one-cycle strobe. With the defaults (a 100 MHz clock divided by 16, and 100 steps per half sweep), the modulation rate is about 31 kHz.

Top module: `sst_downspread_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `offset_o` is 0 and `offset_vld_o` is low.
- R2: `offset_vld_o` is a single-cycle pulse. Once running, consecutive pulses are exactly `UPD_DIV` clock cycles apart.
- R3: Select value 2'b00 (off), and the unused value 2'b11 which also means off, keep every offset at 0.
- R4: Select value 2'b01 (shallow) gives offsets equal to minus the counter value times `STEP`. The shallow peak is `-PEAK*STEP`.
- R5: Select value 2'b10 (deep) uses a step of `2*STEP`. Its peak, `-2*PEAK*STEP`, is exactly twice the shallow peak.
- R6: The offset is never positive and never below `-2*PEAK*STEP`.
- R7: While spreading, consecutive offsets differ by exactly one step. The triangle turns at zero and at the peak, and neither turning sample is repeated.
- R8: A select change takes effect only at an update where the triangle has just been at zero. Every offset within a sweep uses the depth latched at that sweep's start.
- R9: One full sweep takes exactly `2*PEAK` updates. After `2*PEAK` updates from leaving zero, the offset is back at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_sel_i | input | 2 | Depth select: 00 off, 01 shallow, 10 deep, 11 off |
| offset_o | output | OFS_W | Signed offset word, zero or negative |
| offset_vld_o | output | 1 | One-cycle strobe marking a new offset |

## Verification
The delicate coincidence is the triangle's return to zero on the same update where a new select value is waiting. On that update the depth latch and the direction reversal both act at once.

The bench provokes this in two ways. It changes the select in the middle of sweeps and holds it across the zero crossing, and it switches from off to deep exactly when the triangle rests at zero. Each strobed offset is then judged against an independent sweep model. The model applies the new depth only on the first step that leaves zero.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    DEPTH_OFF     = 2'd0,
    DEPTH_SHALLOW = 2'd1,
    DEPTH_DEEP    = 2'd2
  } depth_e;

  // select 00 and 11 both mean no spreading
  function automatic depth_e sel_to_depth(input logic [1:0] sel);
    case (sel)
      2'b01:   return DEPTH_SHALLOW;
      2'b10:   return DEPTH_DEEP;
      default: return DEPTH_OFF;
    endcase
  endfunction

endpackage

// File: rtl/sst_rate_tick.sv
module sst_rate_tick #(
  parameter int UPD_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DW = (UPD_DIV > 1) ? $clog2(UPD_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(UPD_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == LAST);
      if (div_q == LAST) div_q <= '0;
      else               div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sst_triangle.sv
module sst_triangle
  import sst_pkg::*;
#(
  parameter int PEAK = 100,
  parameter int CW   = $clog2(PEAK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] cnt_o,
  output depth_e        depth_o,
  output logic          stepped_o
);
  localparam logic [CW-1:0] TOP_M1 = CW'(PEAK - 1);

  logic   rising_q;
  depth_e next_depth;

  assign next_depth = sel_to_depth(sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o     <= '0;
      rising_q  <= 1'b1;
      depth_o   <= DEPTH_OFF;
      stepped_o <= 1'b0;
    end else begin
      stepped_o <= tick_i;
      if (tick_i) begin
        if (cnt_o == '0) begin
          // depth is only ever latched at the zero point of the sweep
          depth_o <= next_depth;
          if (next_depth != DEPTH_OFF) begin
            cnt_o    <= CW'(1);
            rising_q <= (PEAK != 1);
          end
        end else if (rising_q) begin
          cnt_o <= cnt_o + 1'b1;
          if (cnt_o == TOP_M1) rising_q <= 1'b0;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sst_scale.sv
module sst_scale
  import sst_pkg::*;
#(
  parameter int STEP  = 1395,
  parameter int OFS_W = 20,
  parameter int CW    = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stepped_i,
  input  logic [CW-1:0]           cnt_i,
  input  depth_e                  depth_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    offset_vld_o
);
  localparam int NUM_DEPTH = 3;

  logic [OFS_W-1:0] step_tab [NUM_DEPTH];
  logic [OFS_W-1:0] step_w;
  logic [OFS_W-1:0] mag_w;

  // per-depth step: off, shallow, deep (twice shallow)
  for (genvar g = 0; g < NUM_DEPTH; g++) begin : g_step
    assign step_tab[g] = OFS_W'(g * STEP);
  end

  always_comb begin
    case (depth_i)
      DEPTH_SHALLOW: step_w = step_tab[1];
      DEPTH_DEEP:    step_w = step_tab[2];
      default:       step_w = step_tab[0];
    endcase
    mag_w = OFS_W'(cnt_i) * step_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_o     <= '0;
      offset_vld_o <= 1'b0;
    end else begin
      offset_vld_o <= stepped_i;
      if (stepped_i) offset_o <= -$signed(mag_w);
    end
  end
endmodule

// File: rtl/sst_downspread_gen.sv
module sst_downspread_gen
  import sst_pkg::*;
#(
  parameter int UPD_DIV = 16,
  parameter int PEAK    = 100,
  parameter int STEP    = 1395,
  parameter int OFS_W   = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              spread_sel_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    offset_vld_o
);
  localparam int CW = $clog2(PEAK + 1);

  logic          tick;
  logic [CW-1:0] cnt;
  depth_e        depth;
  logic          stepped;

  sst_rate_tick #(.UPD_DIV(UPD_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  sst_triangle #(.PEAK(PEAK), .CW(CW)) u_tri (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .sel_i     (spread_sel_i),
    .cnt_o     (cnt),
    .depth_o   (depth),
    .stepped_o (stepped)
  );

  sst_scale #(.STEP(STEP), .OFS_W(OFS_W), .CW(CW)) u_scale (
    .clk          (clk),
    .rst          (rst),
    .stepped_i    (stepped),
    .cnt_i        (cnt),
    .depth_i      (depth),
    .offset_o     (offset_o),
    .offset_vld_o (offset_vld_o)
  );
endmodule

// File: rtl/sst_downspread_chk.sv
module sst_downspread_chk #(
  parameter int UPD_DIV = 16,
  parameter int PEAK    = 100,
  parameter int STEP    = 1395,
  parameter int OFS_W   = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [OFS_W-1:0] offset_o,
  input logic                    offset_vld_o
);
  localparam int GW = $clog2(UPD_DIV + 2) + 1;
  localparam logic signed [OFS_W:0] FLOOR = -(OFS_W+1)'(2 * PEAK * STEP);
  localparam logic [OFS_W:0] STEP1 = (OFS_W+1)'(STEP);
  localparam logic [OFS_W:0] STEP2 = (OFS_W+1)'(2 * STEP);

  logic [GW-1:0]           gap_q;
  logic                    seen_q;
  logic signed [OFS_W-1:0] last_q;
  logic [OFS_W:0]          last_mag_q;
  logic signed [OFS_W:0]   delta;
  logic [OFS_W:0]          mag;

  assign delta = (OFS_W+1)'(offset_o) - (OFS_W+1)'(last_q);
  assign mag   = delta[OFS_W] ? (OFS_W+1)'(-delta) : (OFS_W+1)'(delta);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      last_q     <= '0;
      last_mag_q <= '0;
    end else if (offset_vld_o) begin
      gap_q      <= '0;
      seen_q     <= 1'b1;
      last_q     <= offset_o;
      last_mag_q <= mag;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (offset_o == '0 && !offset_vld_o)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) offset_vld_o |=> !offset_vld_o); // R2
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst) (offset_vld_o && seen_q) |-> (gap_q == GW'(UPD_DIV - 1))); // R2
  AST_NOT_POSITIVE: assert property (@(posedge clk) disable iff (rst) !offset_o[OFS_W-1] |-> (offset_o == '0)); // R6
  AST_FLOOR: assert property (@(posedge clk) disable iff (rst) (OFS_W+1)'(offset_o) >= FLOOR); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst) (offset_vld_o && seen_q) |-> ((mag == '0 && offset_o == '0) || mag == STEP1 || mag == STEP2)); // R7
  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (rst) (offset_vld_o && seen_q && last_q != '0 && offset_o != '0) |-> (mag == last_mag_q)); // R8
endmodule

bind sst_downspread_gen sst_downspread_chk #(
  .UPD_DIV(UPD_DIV), .PEAK(PEAK), .STEP(STEP), .OFS_W(OFS_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .offset_o     (offset_o),
  .offset_vld_o (offset_vld_o)
);

// File: tb/tb_sst_downspread_gen.sv
module tb_sst_downspread_gen;
  localparam int UPD_DIV = 4;
  localparam int PEAK    = 5;
  localparam int STEP    = 3;
  localparam int OFS_W   = 12;
  localparam int NV      = 8;

  // stimulus table: select value and number of updates to observe
  localparam logic [1:0] VSEL [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b00, 2'b01, 2'b10};
  localparam int         VCNT [NV] = '{6, 13, 17, 8, 25, 9, 10, 12};

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [1:0]              sel = 2'b00;
  logic signed [OFS_W-1:0] offset;
  logic                    vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_cnt = 0, m_depth = 0;
  bit m_up  = 1;
  int min_sh = 0, min_dp = 0;
  bit have_prev = 0;

  always #5 clk = ~clk;

  sst_downspread_gen #(.UPD_DIV(UPD_DIV), .PEAK(PEAK), .STEP(STEP), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst(rst), .spread_sel_i(sel), .offset_o(offset), .offset_vld_o(vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int depth_of(input logic [1:0] s);
    return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
  endfunction

  task automatic model_step(input logic [1:0] s);
    if (m_cnt == 0) begin
      m_depth = depth_of(s);
      if (m_depth != 0) begin
        m_cnt = 1;
        m_up  = (PEAK != 1);
      end
    end else if (m_up) begin
      m_cnt++;
      if (m_cnt == PEAK) m_up = 0;
    end else begin
      m_cnt--;
    end
  endtask

  // wait for next strobe, check spacing, then compare to the model
  task automatic observe();
    int gap = 0;
    int exp;
    string tag;
    bit was_zero = (m_cnt == 0);
    do begin
      @(negedge clk);
      gap++;
    end while (!vld && gap < 64);
    if (!vld) begin
      check(0, "R2 watchdog", gap, UPD_DIV);
      return;
    end
    if (have_prev) check(gap == UPD_DIV, "R2", gap, UPD_DIV);
    have_prev = 1;
    model_step(sel);
    exp = -(m_cnt * STEP * m_depth);
    if (!was_zero && depth_of(sel) != m_depth) tag = "R8";
    else if (m_depth == 0) tag = "R3";
    else if (m_depth == 1) tag = "R4 R7";
    else tag = "R5 R7";
    check(int'(offset) == exp, tag, int'(offset), exp);
    check(int'(offset) <= 0 && int'(offset) >= -2*PEAK*STEP, "R6", int'(offset), exp);
    if (m_depth == 1 && int'(offset) < min_sh) min_sh = int'(offset);
    if (m_depth == 2 && int'(offset) < min_dp) min_dp = int'(offset);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(offset == '0 && !vld, "R1", int'(offset), 0);
    rst = 1'b0;
    @(negedge clk);
    check(offset == '0 && !vld, "R1", int'(offset), 0);

    for (int v = 0; v < NV; v++) begin
      sel = VSEL[v];
      for (int k = 0; k < VCNT[v]; k++) observe();
    end
    check(min_sh == -PEAK*STEP, "R4 peak", min_sh, -PEAK*STEP);
    check(min_dp == -2*PEAK*STEP, "R5 peak", min_dp, -2*PEAK*STEP);
    check(min_dp == 2*min_sh, "R5 ratio", min_dp, 2*min_sh);

    // R9: full deep sweep launched from a resting zero
    sel = 2'b00;
    while (m_cnt != 0) observe();
    observe();
    sel = 2'b10;
    begin
      int n = 0;
      do begin
        observe();
        n++;
      end while (m_cnt != 0 && n < 4*PEAK);
      check(n == 2*PEAK, "R9", n, 2*PEAK);
    end

    // R1: reset in the middle of a sweep
    sel = 2'b01;
    repeat (3) observe();
    rst = 1'b1;
    @(negedge clk);
    check(offset == '0 && !vld, "R1 mid", int'(offset), 0);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_depth = 0; m_up = 1; have_prev = 0;
    @(negedge clk);
    check(offset == '0 && !vld, "R1 release", int'(offset), 0);
    repeat (2*PEAK + 2) observe();

    finish_run();
  end
endmodule